// File: doc/BRIEF.md
# Memory Leaf Read-Path Controller

This block serves one half of a 128-byte cache-line read from error-corrected DRAM. A requester presents a line address. The controller first decides whether this leaf owns the line. If it does, the controller maps the line to one of its local banks and issues a single memory read command. It then gathers two 256-bit memory beats. Each beat carries four 64-bit words, and every word has an 8-bit SECDED check byte. The controller corrects each word as it arrives and stores the corrected 64-byte half-line.

Once both memory beats are held, the half-line leaves on a 128-bit system bus as four back-to-back beats. A valid strobe and an error flag go with the beats. A single-bit fault is repaired silently and recorded in a sticky flag. A double-bit fault marks the whole burst as bad.

Firmware can switch off banks that failed self-test. A request that maps to a switched-off bank never reaches memory. It is answered at once with a four-beat burst of zeros flagged as bad. Only one request is in flight at a time.

Top module: `leaf_read_ctrl`

## Requirements
- R1: While reset is held and right after it, `req_ready` is 1, and `bus_valid`, `mem_req` and `ce_flag` are 0. Reset is asynchronous active-low, and the block's release from reset is synchronised over two clock edges.
- R2: With `cfg_interleave`=0, a request for any line address is accepted. With `cfg_interleave`=1, only lines whose address bit 0 equals `cfg_leaf_id` are accepted. Any other request is ignored: `req_ready` stays 1, `mem_req` stays 0 and no bus beat appears.
- R3: On the clock after an accepted request to an enabled bank, `mem_req` is 1 for exactly one cycle. With `cfg_interleave`=0, `mem_bank` = address[1:0] and `mem_row` = address[19:2]. With `cfg_interleave`=1, `mem_bank` = address[2:1] and `mem_row` = address[19:3] zero-extended to 18 bits.
- R4: No bus beat is sent until both memory beats (cycles with `mem_rvalid`=1) have been stored. On the clock after the second memory beat, exactly four consecutive `bus_valid` cycles follow. They carry, in this order: bits 127:0 of the first memory beat, bits 255:128 of the first, bits 127:0 of the second, then bits 255:128 of the second.
- R5: Word w of a memory beat is `mem_rdata`[64w+63:64w], and its check byte is `mem_rcheck`[8w+7:8w]. The code is a Hamming code: the 64 data bits fill positions 1 to 71 that are not powers of two, in ascending order, with data bit 0 at position 3. Check bit i (i = 0 to 6) is the XOR of the data bits whose position has bit i set. Check bit 7 is the XOR of all 64 data bits and check bits 0 to 6.
- R6: A single flipped bit in any word, whether in its data or in its check byte, is corrected. The bus carries the original data, and `bus_err` is 0.
- R7: `ce_flag` goes to 1 when any word of a read has been corrected. It then stays 1 until reset, and reads without errors do not clear it.
- R8: Two flipped bits in one word set `bus_err` to 1 on all four bus beats of that read.
- R9: A request that maps to a bank whose `bank_disable` bit is 1 produces no `mem_req`. On the clock after acceptance, it is answered with four beats of all-zero data, each with `bus_err`=1.
- R10: `req_ready` is 0 from the clock after acceptance through the last bus beat, and is 1 on the clock after that beat. `mem_rvalid` pulses while idle or while sending have no effect on the bus data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_interleave | input | 1 | 1 when lines alternate between two leaves |
| cfg_leaf_id | input | 1 | Which parity of line address this leaf owns when interleaved |
| bank_disable | input | 4 | One bit per bank; 1 blocks that bank |
| req_valid | input | 1 | Read request present |
| req_line | input | 20 | Line address of the request |
| req_ready | output | 1 | Controller idle and able to accept |
| mem_req | output | 1 | One-cycle memory read command |
| mem_bank | output | 2 | Bank selected for the command |
| mem_row | output | 18 | Line index within the bank |
| mem_rvalid | input | 1 | Memory read beat present |
| mem_rdata | input | 256 | Memory read data, four 64-bit words |
| mem_rcheck | input | 32 | Check bytes, one per word |
| bus_valid | output | 1 | System-bus beat valid |
| bus_data | output | 128 | System-bus beat data |
| bus_err | output | 1 | Burst holds uncorrectable or blocked data |
| ce_flag | output | 1 | Sticky record of a corrected error |

## Verification
The assertions watch on every cycle several properties. Each bus burst is exactly four beats long. The error flag does not change inside a burst. A memory command lasts one cycle, is issued only while the controller is busy, and never targets a disabled bank. The ready signal is low whenever bus beats flow. The correctable flag never falls once set. Only the bench's scenarios can show that corrected data matches the original words, that beats come out in the stated order, that bank and row follow the address in both interleave modes, and that blocked or foreign requests yield zeros or nothing at all.

// File: rtl/lrc_pkg.sv
package lrc_pkg;

  localparam int WORD_W   = 64;
  localparam int CHK_W    = 8;
  localparam int SYN_W    = 7;
  localparam int CODE_LEN = 72;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_SEND = 2'd2
  } lrc_state_e;

  typedef struct packed {
    logic [WORD_W-1:0] data;
    logic              ce;
    logic              ue;
  } ecc_res_t;

  // Hamming syndrome contribution of the data bits alone.
  function automatic logic [SYN_W-1:0] ham_syn(input logic [WORD_W-1:0] d);
    logic [SYN_W-1:0] s;
    int k;
    s = '0;
    k = 0;
    for (int p = 1; p < CODE_LEN; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (d[k]) s = s ^ SYN_W'(p);
        k = k + 1;
      end
    end
    return s;
  endfunction

  // Check and repair one word.
  function automatic ecc_res_t ecc_fix(input logic [WORD_W-1:0] d,
                                       input logic [CHK_W-1:0]  c);
    ecc_res_t         r;
    logic [SYN_W-1:0] syn;
    logic             par;
    int               k;
    syn    = ham_syn(d) ^ c[SYN_W-1:0];
    par    = (^d) ^ (^c);
    r.data = d;
    r.ce   = 1'b0;
    r.ue   = 1'b0;
    if (par) begin
      if (int'(syn) < CODE_LEN) begin
        r.ce = 1'b1;
        k = 0;
        for (int p = 1; p < CODE_LEN; p++) begin
          if ((p & (p - 1)) != 0) begin
            if (p == int'(syn)) r.data[k] = ~d[k];
            k = k + 1;
          end
        end
      end else begin
        r.ue = 1'b1;
      end
    end else if (syn != '0) begin
      r.ue = 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/lrc_addr_map.sv
module lrc_addr_map #(
  parameter int LINE_AW = 20,
  parameter int NBANK   = 4,
  localparam int BANK_W = $clog2(NBANK),
  localparam int ROW_W  = LINE_AW - BANK_W
) (
  input  logic [LINE_AW-1:0] line,
  input  logic               interleave,
  input  logic               leaf_id,
  input  logic [NBANK-1:0]   disable_mask,
  output logic               mine,
  output logic [BANK_W-1:0]  bank,
  output logic [ROW_W-1:0]   row,
  output logic               blocked
);

  always_comb begin
    if (interleave) begin
      mine = (line[0] == leaf_id);
      bank = line[BANK_W:1];
      row  = {1'b0, line[LINE_AW-1:BANK_W+1]};
    end else begin
      mine = 1'b1;
      bank = line[BANK_W-1:0];
      row  = line[LINE_AW-1:BANK_W];
    end
    blocked = disable_mask[bank];
  end

endmodule

// File: rtl/lrc_ecc_word.sv
module lrc_ecc_word
  import lrc_pkg::*;
(
  input  logic [WORD_W-1:0] raw_data,
  input  logic [CHK_W-1:0]  raw_chk,
  output logic [WORD_W-1:0] fix_data,
  output logic              ce,
  output logic              ue
);

  ecc_res_t res;

  always_comb begin
    res      = ecc_fix(raw_data, raw_chk);
    fix_data = res.data;
    ce       = res.ce;
    ue       = res.ue;
  end

endmodule

// File: rtl/lrc_line_buf.sv
module lrc_line_buf #(
  parameter int MEM_W     = 256,
  parameter int BUS_W     = 128,
  parameter int MEM_BEATS = 2,
  localparam int MB_W      = (MEM_BEATS > 1) ? $clog2(MEM_BEATS) : 1,
  localparam int BUS_BEATS = MEM_BEATS * MEM_W / BUS_W,
  localparam int BB_W      = (BUS_BEATS > 1) ? $clog2(BUS_BEATS) : 1
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [MB_W-1:0]  wr_idx,
  input  logic [MEM_W-1:0] wr_data,
  input  logic [BB_W-1:0]  rd_idx,
  output logic [BUS_W-1:0] rd_data
);

  logic [MEM_BEATS*MEM_W-1:0] flat;

  for (genvar b = 0; b < MEM_BEATS; b++) begin : g_slot
    logic [MEM_W-1:0] slot_q;
    logic             slot_en;

    assign slot_en = wr_en && (wr_idx == MB_W'(b));

    always_ff @(posedge clk) begin
      if (slot_en) slot_q <= wr_data;
    end

    assign flat[b*MEM_W +: MEM_W] = slot_q;
  end

  assign rd_data = flat[rd_idx*BUS_W +: BUS_W];

endmodule

// File: rtl/leaf_read_ctrl.sv
module leaf_read_ctrl
  import lrc_pkg::*;
#(
  parameter int LINE_AW   = 20,
  parameter int NBANK     = 4,
  parameter int MEM_W     = 256,
  parameter int BUS_W     = 128,
  parameter int MEM_BEATS = 2,
  localparam int BANK_W    = $clog2(NBANK),
  localparam int ROW_W     = LINE_AW - BANK_W,
  localparam int WPB       = MEM_W / WORD_W,
  localparam int CHK_TOT   = WPB * CHK_W,
  localparam int MB_W      = (MEM_BEATS > 1) ? $clog2(MEM_BEATS) : 1,
  localparam int BUS_BEATS = MEM_BEATS * MEM_W / BUS_W,
  localparam int BB_W      = (BUS_BEATS > 1) ? $clog2(BUS_BEATS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_interleave,
  input  logic               cfg_leaf_id,
  input  logic [NBANK-1:0]   bank_disable,
  input  logic               req_valid,
  input  logic [LINE_AW-1:0] req_line,
  output logic               req_ready,
  output logic               mem_req,
  output logic [BANK_W-1:0]  mem_bank,
  output logic [ROW_W-1:0]   mem_row,
  input  logic               mem_rvalid,
  input  logic [MEM_W-1:0]   mem_rdata,
  input  logic [CHK_TOT-1:0] mem_rcheck,
  output logic               bus_valid,
  output logic [BUS_W-1:0]   bus_data,
  output logic               bus_err,
  output logic               ce_flag
);

  // Reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Address decode
  logic              am_mine;
  logic              am_blocked;
  logic [BANK_W-1:0] am_bank;
  logic [ROW_W-1:0]  am_row;

  lrc_addr_map #(.LINE_AW(LINE_AW), .NBANK(NBANK)) u_map (
    .line         (req_line),
    .interleave   (cfg_interleave),
    .leaf_id      (cfg_leaf_id),
    .disable_mask (bank_disable),
    .mine         (am_mine),
    .bank         (am_bank),
    .row          (am_row),
    .blocked      (am_blocked)
  );

  // Per-word correction of the incoming beat
  logic [MEM_W-1:0] fixed_beat;
  logic [WPB-1:0]   ce_vec;
  logic [WPB-1:0]   ue_vec;

  for (genvar w = 0; w < WPB; w++) begin : g_ecc
    lrc_ecc_word u_ecc (
      .raw_data (mem_rdata[w*WORD_W +: WORD_W]),
      .raw_chk  (mem_rcheck[w*CHK_W +: CHK_W]),
      .fix_data (fixed_beat[w*WORD_W +: WORD_W]),
      .ce       (ce_vec[w]),
      .ue       (ue_vec[w])
    );
  end

  // State
  lrc_state_e        state_q, state_d;
  logic [MB_W-1:0]   mbeat_q, mbeat_d;
  logic [BB_W-1:0]   bbeat_q, bbeat_d;
  logic              zero_q, zero_d;
  logic              ue_q, ue_d;
  logic              ce_q, ce_d;
  logic              mreq_q, mreq_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic [ROW_W-1:0]  row_q, row_d;
  logic              buf_we;
  logic [BUS_W-1:0]  buf_rd;

  always_comb begin
    state_d = state_q;
    mbeat_d = mbeat_q;
    bbeat_d = bbeat_q;
    zero_d  = zero_q;
    ue_d    = ue_q;
    ce_d    = ce_q;
    mreq_d  = 1'b0;
    bank_d  = bank_q;
    row_d   = row_q;
    buf_we  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid && am_mine) begin
          bank_d  = am_bank;
          row_d   = am_row;
          mbeat_d = '0;
          bbeat_d = '0;
          zero_d  = am_blocked;
          ue_d    = am_blocked;
          if (am_blocked) begin
            state_d = ST_SEND;
          end else begin
            state_d = ST_FILL;
            mreq_d  = 1'b1;
          end
        end
      end
      ST_FILL: begin
        if (mem_rvalid) begin
          buf_we = 1'b1;
          ue_d   = ue_q | (|ue_vec);
          ce_d   = ce_q | (|ce_vec);
          if (mbeat_q == MB_W'(MEM_BEATS - 1)) begin
            state_d = ST_SEND;
            bbeat_d = '0;
          end else begin
            mbeat_d = mbeat_q + 1'b1;
          end
        end
      end
      ST_SEND: begin
        if (bbeat_q == BB_W'(BUS_BEATS - 1)) begin
          state_d = ST_IDLE;
        end else begin
          bbeat_d = bbeat_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      mbeat_q <= '0;
      bbeat_q <= '0;
      zero_q  <= 1'b0;
      ue_q    <= 1'b0;
      ce_q    <= 1'b0;
      mreq_q  <= 1'b0;
      bank_q  <= '0;
      row_q   <= '0;
    end else begin
      state_q <= state_d;
      mbeat_q <= mbeat_d;
      bbeat_q <= bbeat_d;
      zero_q  <= zero_d;
      ue_q    <= ue_d;
      ce_q    <= ce_d;
      mreq_q  <= mreq_d;
      bank_q  <= bank_d;
      row_q   <= row_d;
    end
  end

  lrc_line_buf #(.MEM_W(MEM_W), .BUS_W(BUS_W), .MEM_BEATS(MEM_BEATS)) u_buf (
    .clk     (clk),
    .wr_en   (buf_we),
    .wr_idx  (mbeat_q),
    .wr_data (fixed_beat),
    .rd_idx  (bbeat_q),
    .rd_data (buf_rd)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign mem_req   = mreq_q;
  assign mem_bank  = bank_q;
  assign mem_row   = row_q;
  assign bus_valid = (state_q == ST_SEND);
  assign bus_data  = (bus_valid && !zero_q) ? buf_rd : '0;
  assign bus_err   = bus_valid && ue_q;
  assign ce_flag   = ce_q;

endmodule

// File: rtl/leaf_read_ctrl_chk.sv
module leaf_read_ctrl_chk #(
  parameter int NBANK = 4,
  localparam int BANK_W = $clog2(NBANK)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              mem_req,
  input logic [BANK_W-1:0] mem_bank,
  input logic [NBANK-1:0]  bank_disable,
  input logic              bus_valid,
  input logic              bus_err,
  input logic              ce_flag
);

  logic [2:0] run_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_cnt_q <= '0;
    else if (bus_valid) run_cnt_q <= run_cnt_q + 3'd1;
    else                run_cnt_q <= '0;
  end

  p_memreq_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  p_burst_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_valid) |-> run_cnt_q == 3'd4);

  p_burst_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> run_cnt_q < 3'd4);

  p_ce_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ce_flag |=> ce_flag);

  p_err_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && $past(bus_valid)) |-> $stable(bus_err));

  p_no_mem_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !bank_disable[mem_bank]);

  p_ready_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> !req_ready);

  p_memreq_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);

endmodule

bind leaf_read_ctrl leaf_read_ctrl_chk #(.NBANK(NBANK)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .mem_req      (mem_req),
  .mem_bank     (mem_bank),
  .bank_disable (bank_disable),
  .bus_valid    (bus_valid),
  .bus_err      (bus_err),
  .ce_flag      (ce_flag)
);

// File: tb/leaf_read_ctrl_tb.sv
`timescale 1ns/1ps
module leaf_read_ctrl_tb;

  logic         clk;
  logic         rst_n;
  logic         cfg_interleave;
  logic         cfg_leaf_id;
  logic [3:0]   bank_disable;
  logic         req_valid;
  logic [19:0]  req_line;
  logic         req_ready;
  logic         mem_req;
  logic [1:0]   mem_bank;
  logic [17:0]  mem_row;
  logic         mem_rvalid;
  logic [255:0] mem_rdata;
  logic [31:0]  mem_rcheck;
  logic         bus_valid;
  logic [127:0] bus_data;
  logic         bus_err;
  logic         ce_flag;

  int n_chk  = 0;
  int n_fail = 0;

  leaf_read_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_interleave(cfg_interleave),
    .cfg_leaf_id(cfg_leaf_id), .bank_disable(bank_disable),
    .req_valid(req_valid), .req_line(req_line), .req_ready(req_ready),
    .mem_req(mem_req), .mem_bank(mem_bank), .mem_row(mem_row),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_rcheck(mem_rcheck),
    .bus_valid(bus_valid), .bus_data(bus_data), .bus_err(bus_err),
    .ce_flag(ce_flag)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // Check byte per R5, built bit by bit from the position rule
  function automatic logic [7:0] enc_word(input logic [63:0] d);
    logic [7:0] c;
    int pos [64];
    int n;
    n = 0;
    for (int p = 3; p < 72; p++) begin
      if ((p & (p - 1)) != 0) begin
        pos[n] = p;
        n++;
      end
    end
    c = '0;
    for (int i = 0; i < 7; i++) begin
      for (int j = 0; j < 64; j++) begin
        if (((pos[j] >> i) & 1) == 1) c[i] = c[i] ^ d[j];
      end
    end
    c[7] = (^d) ^ (^c[6:0]);
    return c;
  endfunction

  function automatic logic [31:0] enc_beat(input logic [255:0] b);
    logic [31:0] c;
    for (int w = 0; w < 4; w++) c[8*w +: 8] = enc_word(b[64*w +: 64]);
    return c;
  endfunction

  task automatic do_read(input logic [19:0] addr, input logic [1:0] ebank,
                         input logic [17:0] erow,
                         input logic [255:0] b0, input logic [255:0] b1,
                         input logic [255:0] f0, input logic [255:0] f1,
                         input logic [31:0] cf0, input logic [31:0] cf1,
                         input bit exp_err, input int gap, input bit junk,
                         input string rq);
    logic [127:0] expd;
    logic [31:0]  ck0, ck1;
    ck0 = enc_beat(b0) ^ cf0;
    ck1 = enc_beat(b1) ^ cf1;
    req_valid = 1'b1;
    req_line  = addr;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R10", "ready after accept", 128'(req_ready), 128'd0);
    chk(mem_req == 1'b1, "R3", "mem_req pulse", 128'(mem_req), 128'd1);
    chk(mem_bank == ebank, "R3", "bank", 128'(mem_bank), 128'(ebank));
    chk(mem_row == erow, "R3", "row", 128'(mem_row), 128'(erow));
    for (int g = 0; g < gap; g++) @(negedge clk);
    mem_rvalid = 1'b1;
    mem_rdata  = b0 ^ f0;
    mem_rcheck = ck0;
    @(negedge clk);
    chk(bus_valid == 1'b0, "R4", "no beat after one memory beat", 128'(bus_valid), 128'd0);
    chk(mem_req == 1'b0, "R3", "mem_req single cycle", 128'(mem_req), 128'd0);
    mem_rdata  = b1 ^ f1;
    mem_rcheck = ck1;
    @(negedge clk);
    mem_rvalid = junk;
    mem_rdata  = {8{32'hDEAD_BEEF}};
    mem_rcheck = 32'h0;
    for (int k = 0; k < 4; k++) begin
      expd = (k < 2) ? b0[128*k +: 128] : b1[128*(k-2) +: 128];
      chk(bus_valid == 1'b1, "R4", $sformatf("valid beat %0d", k), 128'(bus_valid), 128'd1);
      chk(req_ready == 1'b0, "R10", $sformatf("ready low beat %0d", k), 128'(req_ready), 128'd0);
      chk(bus_err == exp_err, rq, $sformatf("err beat %0d", k), 128'(bus_err), 128'(exp_err));
      if (!exp_err)
        chk(bus_data == expd, rq, $sformatf("data beat %0d", k), bus_data, expd);
      @(negedge clk);
    end
    mem_rvalid = 1'b0;
    chk(bus_valid == 1'b0, "R4", "burst ends after four", 128'(bus_valid), 128'd0);
    chk(req_ready == 1'b1, "R10", "ready after burst", 128'(req_ready), 128'd1);
  endtask

  function automatic logic [255:0] pat(input logic [31:0] seed);
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[32*i +: 32] = seed * (i + 7) ^ {seed[15:0], seed[31:16]} + i;
    return v;
  endfunction

  task automatic t_reset();
    chk(req_ready == 1'b1, "R1", "ready at reset", 128'(req_ready), 128'd1);
    chk(bus_valid == 1'b0, "R1", "bus_valid at reset", 128'(bus_valid), 128'd0);
    chk(mem_req == 1'b0, "R1", "mem_req at reset", 128'(mem_req), 128'd0);
    chk(ce_flag == 1'b0, "R1", "ce_flag at reset", 128'(ce_flag), 128'd0);
  endtask

  task automatic t_clean_flat();
    logic [19:0] a;
    a = 20'h31236;
    do_read(a, a[1:0], a[19:2], pat(32'h1234_5678), pat(32'h9ABC_DEF0),
            '0, '0, '0, '0, 1'b0, 0, 1'b0, "R4");
    a = 20'hF00F1;
    do_read(a, a[1:0], a[19:2], {64{4'hA}}, {64{4'h5}},
            '0, '0, '0, '0, 1'b0, 3, 1'b0, "R2");
    chk(ce_flag == 1'b0, "R7", "no correction yet", 128'(ce_flag), 128'd0);
  endtask

  task automatic t_spurious();
    logic [19:0] a;
    a = 20'h00003;
    mem_rvalid = 1'b1;
    mem_rdata  = '1;
    mem_rcheck = '1;
    @(negedge clk);
    mem_rvalid = 1'b0;
    chk(bus_valid == 1'b0, "R10", "idle rvalid ignored", 128'(bus_valid), 128'd0);
    do_read(a, a[1:0], a[19:2], pat(32'h0BAD_F00D), pat(32'h7777_1111),
            '0, '0, '0, '0, 1'b0, 1, 1'b1, "R10");
  endtask

  task automatic t_single();
    logic [19:0] a;
    logic [255:0] f1;
    a  = 20'h4000A;
    f1 = '0;
    f1[64*1 + 17] = 1'b1;
    do_read(a, a[1:0], a[19:2], pat(32'hCAFE_0001), pat(32'h0101_CAFE),
            '0, f1, 32'h0400_0000, 32'h0000_0080, 1'b0, 0, 1'b0, "R6");
    chk(ce_flag == 1'b1, "R7", "ce_flag set", 128'(ce_flag), 128'd1);
    do_read(a, a[1:0], a[19:2], pat(32'h5555_0002), pat(32'h2222_3333),
            '0, '0, '0, '0, 1'b0, 0, 1'b0, "R7");
    chk(ce_flag == 1'b1, "R7", "ce_flag sticky", 128'(ce_flag), 128'd1);
  endtask

  task automatic t_double();
    logic [19:0] a;
    logic [255:0] f0;
    a  = 20'h1234C;
    f0 = '0;
    f0[64*2 + 3]  = 1'b1;
    f0[64*2 + 40] = 1'b1;
    do_read(a, a[1:0], a[19:2], pat(32'hFEED_0003), pat(32'h3030_4040),
            f0, '0, '0, '0, 1'b1, 0, 1'b0, "R8");
  endtask

  task automatic t_disabled();
    bank_disable = 4'b1000;
    req_valid = 1'b1;
    req_line  = 20'h5555F;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      chk(mem_req == 1'b0, "R9", "no memory command", 128'(mem_req), 128'd0);
      chk(bus_valid == 1'b1, "R9", $sformatf("blocked beat %0d valid", k), 128'(bus_valid), 128'd1);
      chk(bus_data == '0, "R9", $sformatf("blocked beat %0d zero", k), bus_data, 128'd0);
      chk(bus_err == 1'b1, "R9", $sformatf("blocked beat %0d err", k), 128'(bus_err), 128'd1);
      @(negedge clk);
    end
    chk(req_ready == 1'b1, "R9", "ready after blocked", 128'(req_ready), 128'd1);
    do_read(20'h55554, 2'd0, 18'(20'h55554 >> 2), pat(32'h6060_7070), pat(32'h1F1F_2E2E),
            '0, '0, '0, '0, 1'b0, 0, 1'b0, "R9");
    bank_disable = 4'b0000;
  endtask

  task automatic t_interleave();
    logic [19:0] a;
    cfg_interleave = 1'b1;
    cfg_leaf_id    = 1'b1;
    req_valid = 1'b1;
    req_line  = 20'hABCD4;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b1, "R2", "foreign line ready", 128'(req_ready), 128'd1);
    chk(mem_req == 1'b0, "R2", "foreign line no command", 128'(mem_req), 128'd0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(bus_valid == 1'b0, "R2", "foreign line no beat", 128'(bus_valid), 128'd0);
    end
    a = 20'hABCD5;
    do_read(a, a[2:1], 18'(a >> 3), pat(32'h4242_4242), pat(32'h1357_9BDF),
            '0, '0, '0, '0, 1'b0, 2, 1'b0, "R3");
    cfg_interleave = 1'b0;
    cfg_leaf_id    = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n          = 1'b0;
    cfg_interleave = 1'b0;
    cfg_leaf_id    = 1'b0;
    bank_disable   = 4'b0000;
    req_valid      = 1'b0;
    req_line       = '0;
    mem_rvalid     = 1'b0;
    mem_rdata      = '0;
    mem_rcheck     = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_clean_flat();
    t_spurious();
    t_single();
    t_double();
    t_disabled();
    t_interleave();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule